// File: doc/BRIEF.md
# Low-Frequency RFID Forward-Link Modulator

This block turns a command word into the carrier on/off pattern that a 125 kHz RFID reader uses to talk to a tag. A host loads up to 64 command bits with a bit count and pulses a start strobe. The block then switches the carrier enable through three phases. First comes a start gap with the carrier off. Next comes a short powered interval. Last comes one fixed-length cell per data bit, most significant bit first. All timing is counted in RF periods, marked by a one-cycle tick enable that the surrounding logic derives from the carrier clock.

A one bit leaves the carrier on for the whole cell. A zero bit stops the carrier at the start of its cell and restores it before the cell ends, so the cell length is always 32 periods. This keeps the tag powered through long runs of zeros. The gap length and the zero-bit off time can be rewritten at run time while the block is idle. Their reset values are 55 and 23 periods.

Top module: `lf_fwd_mod`

## Requirements
- R1: After reset, busy and done are 0 and field_enable is 1. field_enable is 1 whenever busy is 0.
- R2: A start pulse in idle with bit_count between 1 and 64 makes busy 1 on the next clock. The carrier is then off for gap-length RF periods, 55 after reset.
- R3: After the gap, the carrier is on for exactly 18 RF periods before the first bit cell.
- R4: A one bit gives a cell of 32 RF periods with field_enable at 1 throughout.
- R5: A zero bit gives a cell of 32 RF periods. field_enable is 0 for the first zero-off periods (23 after reset) and 1 for the rest of the cell.
- R6: With bit_count = n, the bits sent are cmd_word[n-1] down to cmd_word[0], in that order. The upper bits of cmd_word are not used.
- R7: On the clock after the tick that ends the last cell, busy falls to 0 and done is 1 for exactly one clock.
- R8: A start pulse while busy is ignored. The frame in progress continues unchanged.
- R9: A start pulse with bit_count 0 or above 64 is ignored, and busy stays 0.
- R10: cfg_wr in idle with a nonzero cfg_gap loads the gap length and zero-off length used by later frames. cfg_wr while busy is ignored.
- R11: State advances only on clocks with rf_tick at 1. Between ticks, field_enable and busy hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rf_tick | input | 1 | One-cycle pulse per RF carrier period |
| start | input | 1 | Begin sending a frame |
| cmd_word | input | 64 | Command bits; the low bit_count bits are sent |
| bit_count | input | 7 | Number of bits to send, 1 to 64 |
| cfg_wr | input | 1 | Load timing values, accepted only in idle |
| cfg_gap | input | 8 | Start-gap length in RF periods, nonzero |
| cfg_zero_off | input | 5 | Carrier-off length of a zero cell in RF periods |
| field_enable | output | 1 | Carrier enable to the antenna driver |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-clock pulse when a frame completes |

## Verification
A bad period counter or phase state shows up at the ports as soon as the tick ends the affected phase. The carrier edge lands one or more RF periods early or late, which breaks the per-period comparison of field_enable within that gap or cell. A damaged shift register or bit count shows a wrong cell polarity in the first affected cell, or a done pulse one or more cells off from the bit count. Neither fault needs more than one frame to appear.

// File: rtl/lf_fwd_mod.sv
module lf_fwd_mod #(
  parameter int CMD_W      = 64,
  parameter int GAP_W      = 8,
  parameter int OFF_W      = 5,
  parameter int CELL_LEN   = 32,
  parameter int GAP_ON_LEN = 18,
  parameter int DEF_GAP    = 55,
  parameter int DEF_OFF    = 23
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rf_tick,
  input  logic                           start,
  input  logic [CMD_W-1:0]               cmd_word,
  input  logic [$clog2(CMD_W+1)-1:0]     bit_count,
  input  logic                           cfg_wr,
  input  logic [GAP_W-1:0]               cfg_gap,
  input  logic [OFF_W-1:0]               cfg_zero_off,
  output logic                           field_enable,
  output logic                           busy,
  output logic                           done
);
  localparam int NB_W  = $clog2(CMD_W+1);
  localparam int CNT_W = (GAP_W > $clog2(CELL_LEN+1)) ? GAP_W : $clog2(CELL_LEN+1);

  typedef enum logic [1:0] {IDLE, GAP_OFF, GAP_ON, CELL} phase_t;

  phase_t           phase;
  logic [CNT_W-1:0] cnt, limit;
  logic [CMD_W-1:0] shreg;
  logic [NB_W-1:0]  left;
  logic [GAP_W-1:0] gap_len;
  logic [OFF_W-1:0] zero_off;
  logic             count_ok, phase_end;

  assign busy      = (phase != IDLE);
  assign count_ok  = (bit_count != '0) && (bit_count <= NB_W'(CMD_W));
  assign limit     = (phase == GAP_OFF) ? CNT_W'(gap_len) :
                     (phase == GAP_ON)  ? CNT_W'(GAP_ON_LEN) : CNT_W'(CELL_LEN);
  assign phase_end = rf_tick && (cnt == limit - CNT_W'(1));

  assign field_enable = !((phase == GAP_OFF) ||
                          (phase == CELL && !shreg[CMD_W-1] && cnt < CNT_W'(zero_off)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= IDLE;
      cnt      <= '0;
      shreg    <= '0;
      left     <= '0;
      gap_len  <= GAP_W'(DEF_GAP);
      zero_off <= OFF_W'(DEF_OFF);
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase == IDLE) begin
        if (cfg_wr && cfg_gap != '0) begin
          gap_len  <= cfg_gap;
          zero_off <= cfg_zero_off;
        end
        if (start && count_ok) begin
          shreg <= cmd_word << (NB_W'(CMD_W) - bit_count);
          left  <= bit_count;
          cnt   <= '0;
          phase <= GAP_OFF;
        end
      end else if (rf_tick) begin
        if (phase_end) begin
          cnt <= '0;
          case (phase)
            GAP_OFF: phase <= GAP_ON;
            GAP_ON:  phase <= CELL;
            default: begin
              if (left == NB_W'(1)) begin
                phase <= IDLE;
                done  <= 1'b1;
              end else begin
                left  <= left - NB_W'(1);
                shreg <= shreg << 1;
              end
            end
          endcase
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  assert_idle_field_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> field_enable);
  assert_cell_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == CELL) |-> (cnt < CNT_W'(CELL_LEN)));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !rf_tick) |=> ($stable(shreg) && $stable(left)));
  assert_cfg_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(gap_len) && $stable(zero_off)));
  assert_tick_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rf_tick) |=> ($stable(field_enable) && busy));
endmodule

// File: tb/lf_fwd_mod_test.sv
module lf_fwd_mod_test;
  logic        clk = 0, rst_n = 0, rf_tick = 0, start = 0, cfg_wr = 0;
  logic [63:0] cmd_word = '0;
  logic [6:0]  bit_count = '0;
  logic [7:0]  cfg_gap = '0;
  logic [4:0]  cfg_zero_off = '0;
  logic        field_enable, busy, done;
  int          n_checks = 0, n_fail = 0;
  bit          finished = 0;

  always #5 clk = ~clk;

  lf_fwd_mod uut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_field(input int p, input logic [63:0] w, input int n,
                                   input int g, input int z);
    int q;
    if (p < g) return 1'b0;
    q = p - g;
    if (q < 18) return 1'b1;
    q = q - 18;
    if (w[n-1-q/32]) return 1'b1;
    return (q % 32) >= z;
  endfunction

  // mode: 0 none, 1 start during run, 2 cfg_wr during run
  task automatic run_frame(input logic [63:0] w, input int n, input int g, input int z,
                           input int inj_p, input int mode, input int pre_wait,
                           input string req);
    int total, bad, first_bad;
    bit got_first, exp_first;
    total = g + 18 + 32*n;
    bad = 0; first_bad = -1; got_first = 0; exp_first = 0;
    @(negedge clk);
    cmd_word = w; bit_count = 7'(n); start = 1;
    @(negedge clk);
    start = 0;
    check(busy == 1, "R2", "busy after start", busy, 1);
    if (pre_wait > 0) begin
      repeat (pre_wait) @(negedge clk);
      check(busy == 1 && field_enable == 0, "R11", "hold without tick",
            {busy, field_enable}, 2);
    end
    for (int p = 0; p < total; p++) begin
      rf_tick = 1;
      if (field_enable !== exp_field(p, w, n, g, z)) begin
        if (bad == 0) begin
          first_bad = p; got_first = field_enable; exp_first = exp_field(p, w, n, g, z);
        end
        bad++;
      end
      @(negedge clk);
      rf_tick = 0;
      if (p == total - 1) begin
        check(done == 1 && busy == 0, "R7", "done/busy at end", {done, busy}, 2);
        @(negedge clk);
        check(done == 0, "R7", "done single pulse", done, 0);
        check(field_enable == 1, "R1", "field on after frame", field_enable, 1);
      end else begin
        if (p == inj_p && mode == 1) begin
          cmd_word = ~w; bit_count = 7'd5; start = 1;
        end
        if (p == inj_p && mode == 2) begin
          cfg_wr = 1; cfg_gap = 8'd7; cfg_zero_off = 5'd3;
        end
        @(negedge clk);
        start = 0; cfg_wr = 0;
        @(negedge clk);
        @(negedge clk);
      end
    end
    if (bad != 0)
      $display("FAIL %s waveform period %0d: actual %0d expected %0d (%0d bad periods)",
               req, first_bad, got_first, exp_first, bad);
    n_checks++;
    if (bad != 0) n_fail++;
  endtask

  task automatic t_reset;
    check(busy == 0, "R1", "busy after reset", busy, 0);
    check(done == 0, "R1", "done after reset", done, 0);
    check(field_enable == 1, "R1", "field after reset", field_enable, 1);
  endtask

  task automatic t_ones;
    run_frame(64'hF, 4, 55, 23, -1, 0, 0, "R3 R4");
  endtask

  task automatic t_pattern;
    run_frame(64'hA5, 8, 55, 23, -1, 0, 0, "R5 R6");
    run_frame(64'h1234_0000_0000_0006, 3, 55, 23, -1, 0, 0, "R6");
  endtask

  task automatic t_full_and_busy_start;
    run_frame(64'h8000_0000_F0F0_3C01, 64, 55, 23, 100, 1, 0, "R8");
  endtask

  task automatic t_bad_count;
    @(negedge clk); cmd_word = 64'hFF; bit_count = 7'd0; start = 1;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    check(busy == 0, "R9", "count 0 ignored", busy, 0);
    bit_count = 7'd65; start = 1;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    check(busy == 0 && field_enable == 1, "R9", "count 65 ignored", busy, 0);
  endtask

  task automatic t_cfg;
    @(negedge clk); cfg_wr = 1; cfg_gap = 8'd20; cfg_zero_off = 5'd10;
    @(negedge clk); cfg_wr = 0;
    run_frame(64'h2, 3, 20, 10, 10, 2, 0, "R10");
    run_frame(64'h5, 3, 20, 10, -1, 0, 0, "R10");
  endtask

  task automatic t_tick_gate;
    run_frame(64'h1, 2, 20, 10, -1, 0, 20, "R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ones();
    t_pattern();
    t_full_and_busy_start();
    t_bad_count();
    t_cfg();
    t_tick_gate();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule